// File: doc/BRIEF.md
# Bidirectional LCD Common Scan Driver

This block is the digital core of a row (common) driver for a dot-matrix liquid crystal panel. A chain of 64 flip-flops holds the scan pattern. On every shift event the pattern moves one place, and each flip-flop drives one common select flag. The analog output stage pairs each flag with the AC-inversion level to choose the drive voltage.

The block runs in one of two modes. In master mode it divides the system clock into a shift clock. It also counts lines to produce a frame-start pulse, which is fed into the chain as the scan bit, and it flips the AC-inversion level once per frame. The frame length is 48, 64, 96 or 128 lines. In slave mode an external controller supplies the shift clock, the AC level and the frame-start bit. The bit enters at the end picked by the shift direction.

The two chain-end pins are bidirectional, and so are the clock and AC pins. Each is modelled as separate input, output and output-enable signals. All logic is synchronous to one clock with an active-high synchronous reset. In slave mode the external shift clock is sampled, and a 0-to-1 transition counts as a shift event.

Top module: `lcd_row_scan`

## Requirements
- R1: While `rst` is high at a clock edge, the edge clears every stage of `com` and clears `ac_out` to 0. It also restarts the line count at line 0.
- R2: With `dir_up`=1, a shift event moves `com[0]` to `com[1]` and so on up the chain, and the incoming bit lands in `com[0]`. With `dir_up`=0 the movement is mirrored: the incoming bit lands in `com[63]`. Without a shift event, `com` holds its value.
- R3: In slave mode (`master`=0), a shift event occurs at each clock edge where `sclk_in` is 1 and was 0 at the previous edge. The incoming bit is `dl_in` when `dir_up`=1 and `dr_in` when `dir_up`=0. The pin on the other end is ignored.
- R4: In slave mode, the pin on the input end is an input and the opposite end pin is an output: `dl_oe`=!`dir_up` and `dr_oe`=`dir_up`. `sclk_oe`, `ac_oe` and `frm_oe` are 0, and `frm_out` and `sclk_out` are 0.
- R5: In master mode, `dl_oe`, `dr_oe`, `sclk_oe`, `ac_oe` and `frm_oe` are all 1. The inputs `sclk_in`, `dl_in`, `dr_in` and `ac_in` have no effect.
- R6: In both modes, `dl_out` equals `com[0]` and `dr_out` equals `com[63]`.
- R7: In master mode, a shift event occurs once every CLK_DIV clocks. The first one falls at the CLK_DIV-th edge after reset is released. `sclk_out` is 0 for the first CLK_DIV/2 clocks of each period and 1 for the rest, so it falls at the edge that shifts.
- R8: In master mode, `duty_sel` sets the frame length in shift periods: 00=48, 01=64, 10=96, 11=128. `frm_out` is 1 during line 0 of each frame, which lasts exactly one shift period. Consecutive rises of `frm_out` are therefore lines×CLK_DIV clocks apart.
- R9: In master mode, the bit shifted into the input end is the current `frm_out` value. A single 1 therefore walks through the chain once per frame.
- R10: In master mode, `ac_out` inverts exactly at the edge that ends the last line of a frame, which is the same edge at which `frm_out` rises. At all other times it holds its value.
- R11: `ac_level`, the AC level handed to the analog stage, equals `ac_out` in master mode and `ac_in` in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| master | input | 1 | 1 = generate timing internally, 0 = follow external controller |
| dir_up | input | 1 | 1 = scan from end 0 upward, 0 = from end 63 downward |
| duty_sel | input | 2 | Frame length select in master mode |
| sclk_in | input | 1 | External shift clock (slave) |
| sclk_out | output | 1 | Generated shift clock (master) |
| sclk_oe | output | 1 | Drive enable for the shift clock pin |
| ac_in | input | 1 | External AC-inversion level (slave) |
| ac_out | output | 1 | Generated AC-inversion level |
| ac_oe | output | 1 | Drive enable for the AC pin |
| ac_level | output | 1 | AC level used by the analog stage |
| frm_out | output | 1 | Frame-start pulse (master) |
| frm_oe | output | 1 | Drive enable for the frame pin |
| dl_in | input | 1 | Low-end chain pin, input side |
| dl_out | output | 1 | Low-end chain pin, output side |
| dl_oe | output | 1 | Drive enable for the low-end pin |
| dr_in | input | 1 | High-end chain pin, input side |
| dr_out | output | 1 | High-end chain pin, output side |
| dr_oe | output | 1 | Drive enable for the high-end pin |
| com | output | 64 | Common select flags, one per row |

## Verification
The embedded properties check the following on every cycle:
- the entry bit at the active chain end and the freezing of the chain between shift events;
- that the line count only moves on a shift event and that AC only flips at line 0;
- the one-input/one-output rule for the end pins in slave mode, and that the edge detector fires on an external clock rise;
- that the end pins match the first and last stages.

Only the bench scenarios can show the properties that span a frame:
- the real frame period for each duty code;
- that a single bit walks the whole chain and leaves at the far pin;
- that repeated levels or held-high external clocks do not add shifts;
- that the ignored pins really leave the chain untouched.

// File: rtl/lcd_scan_pkg.sv
`timescale 1ns/1ps
package lcd_scan_pkg;

    // Width of the line counter; covers the longest frame of 128 lines.
    localparam int LINE_W = 7;

    typedef enum logic [1:0] {
        DUTY_48  = 2'b00,
        DUTY_64  = 2'b01,
        DUTY_96  = 2'b10,
        DUTY_128 = 2'b11
    } duty_e;

    // One request to the scan chain.
    typedef struct packed {
        logic shift;
        logic din;
    } shift_req_t;

    // Drive enables of the bidirectional pins.
    typedef struct packed {
        logic dl;
        logic dr;
        logic sclk;
        logic ac;
        logic frm;
    } pin_dir_t;

    // Index of the last line of a frame for a given duty code.
    function automatic logic [LINE_W-1:0] last_line(input duty_e d);
        case (d)
            DUTY_48:  return LINE_W'(47);
            DUTY_64:  return LINE_W'(63);
            DUTY_96:  return LINE_W'(95);
            default:  return LINE_W'(127);
        endcase
    endfunction

endpackage

// File: rtl/lcd_scan_timing.sv
`timescale 1ns/1ps
module lcd_scan_timing
    import lcd_scan_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  master,
    input  duty_e duty,
    output logic  tick,
    output logic  frm,
    output logic  sclk_hi,
    output logic  ac
);

    localparam int              PRE_W    = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_DIV - 1);
    localparam logic [PRE_W-1:0] PRE_HALF = PRE_W'(CLK_DIV / 2);

    logic [PRE_W-1:0]  pre_q;
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] line_end;
    logic              wrap;
    logic              ac_q;

    assign line_end = last_line(duty);
    assign wrap     = (line_q >= line_end);

    // Clock prescaler: runs only while generating timing.
    always_ff @(posedge clk) begin
        if (rst || !master) begin
            pre_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick    = master && (pre_q == PRE_LAST);
    assign sclk_hi = master && (pre_q >= PRE_HALF);

    // Line counter within a frame.
    always_ff @(posedge clk) begin
        if (rst || !master) begin
            line_q <= '0;
        end else if (tick) begin
            line_q <= wrap ? '0 : line_q + 1'b1;
        end
    end

    assign frm = master && (line_q == '0);

    // AC inversion level, flipped at the end of each frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            ac_q <= 1'b0;
        end else if (tick && wrap) begin
            ac_q <= ~ac_q;
        end
    end

    assign ac = ac_q;

    // R8
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (master && $past(master) && !$past(rst) && !$past(tick)) |-> $stable(line_q));

    // R10
    ac_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(ac_q)) |-> (line_q == '0));

endmodule

// File: rtl/lcd_scan_shifter.sv
`timescale 1ns/1ps
module lcd_scan_shifter #(
    parameter int NUM_STAGES = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift,
    input  logic                  dir_up,
    input  logic                  din,
    output logic [NUM_STAGES-1:0] q
);

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        logic from_lo;
        logic from_hi;
        logic stage_q;

        if (g == 0) begin : g_lo_end
            assign from_lo = din;
        end else begin : g_lo_mid
            assign from_lo = q[g-1];
        end

        if (g == NUM_STAGES - 1) begin : g_hi_end
            assign from_hi = din;
        end else begin : g_hi_mid
            assign from_hi = q[g+1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q <= 1'b0;
            end else if (shift) begin
                stage_q <= dir_up ? from_lo : from_hi;
            end
        end

        assign q[g] = stage_q;
    end

    // R2
    up_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (shift && dir_up) |=> (q[0] == $past(din)));

    // R2
    down_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (shift && !dir_up) |=> (q[NUM_STAGES-1] == $past(din)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(q));

endmodule

// File: rtl/lcd_scan_portctl.sv
`timescale 1ns/1ps
module lcd_scan_portctl
    import lcd_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       master,
    input  logic       dir_up,
    input  logic       sclk_in,
    input  logic       dl_in,
    input  logic       dr_in,
    input  logic       ac_in,
    input  logic       m_tick,
    input  logic       m_frm,
    input  logic       m_sclk,
    input  logic       m_ac,
    input  logic       end_lo,
    input  logic       end_hi,
    output shift_req_t req,
    output pin_dir_t   dirs,
    output logic       dl_out,
    output logic       dr_out,
    output logic       sclk_out,
    output logic       ac_out,
    output logic       frm_out,
    output logic       ac_level
);

    logic sclk_prev;
    logic slave_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk_in;
        end
    end

    assign slave_edge = !master && sclk_in && !sclk_prev;

    always_comb begin
        req.shift = master ? m_tick : slave_edge;
        req.din   = master ? m_frm : (dir_up ? dl_in : dr_in);
    end

    always_comb begin
        dirs.dl   = master || !dir_up;
        dirs.dr   = master || dir_up;
        dirs.sclk = master;
        dirs.ac   = master;
        dirs.frm  = master;
    end

    assign dl_out   = end_lo;
    assign dr_out   = end_hi;
    assign sclk_out = m_sclk;
    assign ac_out   = m_ac;
    assign frm_out  = m_frm;
    assign ac_level = master ? m_ac : ac_in;

    // R4
    slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !master |-> (!frm_out && !sclk_out && !dirs.frm && !dirs.sclk));

    // R4
    slave_one_input_chk: assert property (@(posedge clk) disable iff (rst)
        !master |-> ($countones({dirs.dl, dirs.dr}) == 1));

    // R3
    slave_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!master && !$past(rst) && sclk_in && !$past(sclk_in)) |-> req.shift);

endmodule

// File: rtl/lcd_row_scan.sv
`timescale 1ns/1ps
module lcd_row_scan
    import lcd_scan_pkg::*;
#(
    parameter int NUM_COM = 64,
    parameter int CLK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               master,
    input  logic               dir_up,
    input  logic [1:0]         duty_sel,
    input  logic               sclk_in,
    output logic               sclk_out,
    output logic               sclk_oe,
    input  logic               ac_in,
    output logic               ac_out,
    output logic               ac_oe,
    output logic               ac_level,
    output logic               frm_out,
    output logic               frm_oe,
    input  logic               dl_in,
    output logic               dl_out,
    output logic               dl_oe,
    input  logic               dr_in,
    output logic               dr_out,
    output logic               dr_oe,
    output logic [NUM_COM-1:0] com
);

    logic       t_tick;
    logic       t_frm;
    logic       t_sclk;
    logic       t_ac;
    shift_req_t req;
    pin_dir_t   dirs;

    lcd_scan_timing #(
        .CLK_DIV (CLK_DIV)
    ) i_timing (
        .clk     (clk),
        .rst     (rst),
        .master  (master),
        .duty    (duty_e'(duty_sel)),
        .tick    (t_tick),
        .frm     (t_frm),
        .sclk_hi (t_sclk),
        .ac      (t_ac)
    );

    lcd_scan_portctl i_portctl (
        .clk      (clk),
        .rst      (rst),
        .master   (master),
        .dir_up   (dir_up),
        .sclk_in  (sclk_in),
        .dl_in    (dl_in),
        .dr_in    (dr_in),
        .ac_in    (ac_in),
        .m_tick   (t_tick),
        .m_frm    (t_frm),
        .m_sclk   (t_sclk),
        .m_ac     (t_ac),
        .end_lo   (com[0]),
        .end_hi   (com[NUM_COM-1]),
        .req      (req),
        .dirs     (dirs),
        .dl_out   (dl_out),
        .dr_out   (dr_out),
        .sclk_out (sclk_out),
        .ac_out   (ac_out),
        .frm_out  (frm_out),
        .ac_level (ac_level)
    );

    lcd_scan_shifter #(
        .NUM_STAGES (NUM_COM)
    ) i_shifter (
        .clk    (clk),
        .rst    (rst),
        .shift  (req.shift),
        .dir_up (dir_up),
        .din    (req.din),
        .q      (com)
    );

    assign dl_oe   = dirs.dl;
    assign dr_oe   = dirs.dr;
    assign sclk_oe = dirs.sclk;
    assign ac_oe   = dirs.ac;
    assign frm_oe  = dirs.frm;

    // R6
    end_pins_chk: assert property (@(posedge clk) disable iff (rst)
        (dl_out == com[0]) && (dr_out == com[NUM_COM-1]));

    // R5
    master_drive_chk: assert property (@(posedge clk) disable iff (rst)
        master |-> (dl_oe && dr_oe && sclk_oe && ac_oe && frm_oe));

endmodule

// File: tb/test_lcd_row_scan.sv
`timescale 1ns/1ps
module test_lcd_row_scan;

    localparam int NUM = 64;
    localparam int DIV = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           master = 1'b0;
    logic           dir_up = 1'b1;
    logic [1:0]     duty_sel = 2'b00;
    logic           sclk_in = 1'b0;
    logic           ac_in = 1'b0;
    logic           dl_in = 1'b0;
    logic           dr_in = 1'b0;
    logic           sclk_out, sclk_oe, ac_out, ac_oe, ac_level;
    logic           frm_out, frm_oe, dl_out, dl_oe, dr_out, dr_oe;
    logic [NUM-1:0] com;

    lcd_row_scan #(.NUM_COM(NUM), .CLK_DIV(DIV)) i_lcd_row_scan (
        .clk(clk), .rst(rst), .master(master), .dir_up(dir_up), .duty_sel(duty_sel),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .ac_in(ac_in), .ac_out(ac_out), .ac_oe(ac_oe), .ac_level(ac_level),
        .frm_out(frm_out), .frm_oe(frm_oe),
        .dl_in(dl_in), .dl_out(dl_out), .dl_oe(dl_oe),
        .dr_in(dr_in), .dr_out(dr_out), .dr_oe(dr_oe),
        .com(com)
    );

    always #2.5 clk = ~clk;

    // Reference model state
    logic [NUM-1:0] m_com = '0;
    int             m_pre = 0;
    int             m_line = 0;
    logic           m_ac = 1'b0;
    logic           m_sprev = 1'b0;

    int    n_checks = 0;
    int    n_fails = 0;
    string com_tag = "R2";
    bit    done = 1'b0;
    int    cyc = 0;

    function automatic int lines_of(input logic [1:0] d);
        case (d)
            2'b00:   return 48;
            2'b01:   return 64;
            2'b10:   return 96;
            default: return 128;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Advance the model by one edge using the inputs currently applied.
    task automatic model_step();
        logic bit_in;
        logic do_shift;
        bit_in   = 1'b0;
        do_shift = 1'b0;
        if (rst) begin
            m_com = '0; m_pre = 0; m_line = 0; m_ac = 1'b0; m_sprev = 1'b0;
        end else begin
            if (master) begin
                bit_in = (m_line == 0);
                if (m_pre == DIV - 1) begin
                    do_shift = 1'b1;
                    m_pre = 0;
                    if (m_line >= lines_of(duty_sel) - 1) begin
                        m_line = 0;
                        m_ac = ~m_ac;
                    end else begin
                        m_line++;
                    end
                end else begin
                    m_pre++;
                end
            end else begin
                m_pre = 0;
                m_line = 0;
                if (sclk_in && !m_sprev) begin
                    do_shift = 1'b1;
                    bit_in = dir_up ? dl_in : dr_in;
                end
            end
            if (do_shift) begin
                if (dir_up) m_com = {m_com[NUM-2:0], bit_in};
                else        m_com = {bit_in, m_com[NUM-1:1]};
            end
            m_sprev = sclk_in;
        end
    endtask

    task automatic compare();
        logic       e_frm;
        logic       e_sclk;
        logic [4:0] e_oe;
        e_frm  = master && (m_line == 0);
        e_sclk = master && (m_pre >= DIV / 2);
        e_oe   = master ? 5'b11111 : {!dir_up, dir_up, 3'b000};
        chk(com === m_com, com_tag, 64'(com), 64'(m_com));
        chk(frm_out === e_frm, "R8", 64'(frm_out), 64'(e_frm));
        chk(sclk_out === e_sclk, "R7", 64'(sclk_out), 64'(e_sclk));
        chk(ac_out === m_ac, "R10", 64'(ac_out), 64'(m_ac));
        chk(ac_level === (master ? m_ac : ac_in), "R11", 64'(ac_level), 64'(master ? m_ac : ac_in));
        chk({dl_oe, dr_oe, sclk_oe, ac_oe, frm_oe} === e_oe, master ? "R5" : "R4",
            64'({dl_oe, dr_oe, sclk_oe, ac_oe, frm_oe}), 64'(e_oe));
        chk({dl_out, dr_out} === {m_com[0], m_com[NUM-1]}, "R6",
            64'({dl_out, dr_out}), 64'({m_com[0], m_com[NUM-1]}));
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        #1;
        cyc++;
        compare();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic slave_pulse(input logic bit_in);
        if (dir_up) dl_in = bit_in; else dr_in = bit_in;
        sclk_in = 1'b1;
        step();
        sclk_in = 1'b0;
        if (dir_up) dl_in = 1'b0; else dr_in = 1'b0;
        step();
    endtask

    // Master run with frame-period and AC checks at each frame start.
    task automatic master_run(input logic [1:0] d, input logic up, input int n_cycles, input bit noisy);
        int   last_rise;
        logic prev_frm;
        logic prev_ac;
        master = 1'b1; duty_sel = d; dir_up = up; com_tag = "R9";
        last_rise = -1;
        prev_frm = frm_out;
        prev_ac = ac_out;
        for (int i = 0; i < n_cycles; i++) begin
            if (noisy) begin
                sclk_in = 1'($urandom_range(0, 1));
                dl_in   = 1'($urandom_range(0, 1));
                dr_in   = 1'($urandom_range(0, 1));
                ac_in   = 1'($urandom_range(0, 1));
            end
            step();
            if (frm_out && !prev_frm) begin
                // R10: the AC level flips at the frame start edge
                chk(ac_out !== prev_ac, "R10", 64'(ac_out), 64'(~prev_ac));
                if (last_rise >= 0) begin
                    // R8: frame period
                    chk((cyc - last_rise) == lines_of(d) * DIV, "R8",
                        64'(cyc - last_rise), 64'(lines_of(d) * DIV));
                end
                last_rise = cyc;
            end
            prev_frm = frm_out;
            prev_ac = ac_out;
        end
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));

        // R1: reset state, with master mode requested during reset
        master = 1'b1;
        do_reset();
        chk(com === '0, "R1", 64'(com), 64'd0);
        chk(ac_out === 1'b0, "R1", 64'(ac_out), 64'd0);
        chk(frm_out === 1'b1, "R1", 64'(frm_out), 64'd1);

        // R7: first master shift at the DIV-th edge after reset release
        com_tag = "R7";
        for (int i = 0; i < DIV - 1; i++) begin
            step();
            chk(com === '0, "R7", 64'(com), 64'd0);
        end
        step();
        chk(com[0] === 1'b1, "R7", 64'(com), 64'd1);

        // Master runs over all duty codes and both directions
        for (int d = 0; d < 4; d++) begin
            do_reset();
            master_run(2'(d), d[0], 2 * lines_of(2'(d)) * DIV + 3 * DIV, 1'b1);
        end

        // Slave mode: single bit walks the whole chain upward (R3)
        master = 1'b0; dir_up = 1'b1; com_tag = "R3";
        do_reset();
        slave_pulse(1'b1);
        chk(com[0] === 1'b1, "R3", 64'(com), 64'd1);
        for (int i = 1; i < NUM; i++) slave_pulse(1'b0);
        chk(dr_out === 1'b1, "R3", 64'(dr_out), 64'd1);
        slave_pulse(1'b0);
        chk(com === '0, "R3", 64'(com), 64'd0);

        // Held-high external clock shifts only once (R3)
        sclk_in = 1'b1; dl_in = 1'b1;
        for (int i = 0; i < 6; i++) step();
        chk(com === 64'd1, "R3", 64'(com), 64'd1);
        sclk_in = 1'b0; dl_in = 1'b0;
        step();

        // Downward, with the low-end pin toggling and ignored (R2)
        dir_up = 1'b0; com_tag = "R2";
        do_reset();
        for (int i = 0; i < NUM + 2; i++) begin
            dl_in = 1'b1;
            dr_in = (i == 0);
            sclk_in = 1'b1;
            step();
            sclk_in = 1'b0;
            dl_in = 1'b0;
            step();
            if (i == NUM - 1) chk(dl_out === 1'b1, "R2", 64'(dl_out), 64'd1);
        end
        chk(com === '0, "R2", 64'(com), 64'd0);

        // Random slave traffic (R3, R4, R11)
        com_tag = "R3";
        for (int i = 0; i < 3000; i++) begin
            sclk_in = ($urandom_range(0, 2) == 0);
            dl_in   = 1'($urandom_range(0, 1));
            dr_in   = 1'($urandom_range(0, 1));
            ac_in   = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 99) == 0) dir_up = ~dir_up;
            step();
        end

        // Random mode, duty and direction changes mid-run
        com_tag = "R2";
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 499) == 0) master = ~master;
            if ($urandom_range(0, 399) == 0) duty_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 299) == 0) dir_up = ~dir_up;
            sclk_in = 1'($urandom_range(0, 1));
            dl_in   = 1'($urandom_range(0, 1));
            dr_in   = 1'($urandom_range(0, 1));
            ac_in   = 1'($urandom_range(0, 1));
            rst     = ($urandom_range(0, 1999) == 0);
            step();
        end
        rst = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule